// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a translation table held in memory. A requester presents a virtual address with a valid/ready handshake. The walker then issues one or two word reads on a simple read port. Each read is a single-cycle request pulse, answered later by a single-cycle response pulse that carries the descriptor. When the walk ends, the walker returns the physical address together with its attributes, or a fault.

The table has two levels. The low two bits of each descriptor decide how the walk continues. At the first level a descriptor can end the walk as a 1 MB section, point to a 256-entry second-level table, or fault. At the second level a descriptor can give a 4 KB small page or fault. When translation is switched off, the address passes straight through and no read is made. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: If `xlat_en` is 0 when a request is accepted, no read is issued. `res_valid` pulses in the cycle after acceptance with `res_paddr` equal to the virtual address and all other result fields 0.
- R2: The first read goes to address {`tbl_base`[31:14], va[31:20], 2'b00}. Bits [13:0] of `tbl_base` have no effect.
- R3: A first-level descriptor d with d[1:0]=2'b10 ends the walk as a section with these results: `res_paddr` = {d[31:20], va[19:0]}, `res_cacheable` = d[3], `res_bufferable` = d[2], `res_domain` = d[8:5] and `res_page` = 0.
- R4: A first-level descriptor d with d[1:0]=2'b01 causes exactly one more read, at {d[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor e with e[1]=1 gives a small page with these results: `res_paddr` = {e[31:12], va[11:0]}, `res_cacheable` = e[3], `res_bufferable` = e[2], `res_domain` taken from bits [8:5] of the first-level descriptor, and `res_page` = 1.
- R6: A first-level descriptor with d[1:0] equal to 2'b00 or 2'b11 ends the walk after one read with `res_fault` = 1 and every other result field 0.
- R7: A second-level descriptor with e[1:0] equal to 2'b00 or 2'b01 ends the walk with `res_fault` = 1 and every other result field 0.
- R8: `req_ready` is 1 only while no walk is in progress and no result is pending. A request presented while busy is ignored.
- R9: `res_valid` and `mem_req` are single-cycle pulses, and no read is issued in the cycle that carries a result.
- R10: `tbl_base` and `xlat_en` are sampled when a request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable |
| tbl_base | input | 32 | First-level table base; bits [31:14] used |
| req_valid | input | 1 | Translation request valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Descriptor read response pulse |
| mem_rsp_data | input | 32 | Descriptor returned by memory |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_cacheable | output | 1 | Cacheable attribute |
| res_bufferable | output | 1 | Bufferable attribute |
| res_domain | output | 4 | Domain number from first-level descriptor |
| res_page | output | 1 | 1 for small page, 0 for section or pass-through |
| res_fault | output | 1 | Translation fault |

## Verification
The assertions check on every cycle the properties that hold for any walk:
- a read is made only when translation was enabled at acceptance;
- the index fields of each read address match the latched virtual address;
- a section or page result keeps the untranslated offset bits;
- a fault result carries no address;
- result and read pulses last one cycle.

Only the bench scenarios can show the translated upper bits, the attribute and domain sourcing, and the fault encodings. The same holds for sampling the base and enable at acceptance, and for ignoring requests that arrive mid-walk. The bench checks each of these against its own model across directed and random descriptors.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW        = 32;
  localparam int SEC_W     = 20;
  localparam int PG_W      = 12;
  localparam int TBL_ALIGN = 14;
  localparam int L2_ALIGN  = 10;
  localparam int DOM_LO    = 5;
  localparam int DOM_W     = 4;
  localparam int C_BIT     = 3;
  localparam int B_BIT     = 2;
  localparam int L1_IDX_W  = AW - SEC_W;
  localparam int L2_IDX_W  = SEC_W - PG_W;
  localparam int BASE_HI_W = AW - TBL_ALIGN;
  localparam int TBL_HI_W  = AW - L2_ALIGN;
  localparam int FRAME_W   = AW - PG_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {DK_FAULT, DK_SECTION, DK_COARSE, DK_PAGE} desc_kind_e;

  typedef struct packed {
    logic [AW-1:0]    pa;
    logic             cach;
    logic             buff;
    logic [DOM_W-1:0] dom;
    logic             page;
    logic             fault;
  } xlat_res_t;

  function automatic logic [AW-1:0] l1_addr(input logic [BASE_HI_W-1:0] base_hi,
                                           input logic [L1_IDX_W-1:0] idx);
    return {base_hi, idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_addr(input logic [TBL_HI_W-1:0] tbl_hi,
                                           input logic [L2_IDX_W-1:0] idx);
    return {tbl_hi, idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] sect_pa(input logic [L1_IDX_W-1:0] frame,
                                           input logic [SEC_W-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic [AW-1:0] page_pa(input logic [FRAME_W-1:0] frame,
                                           input logic [PG_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
(
  input  logic       lvl2,
  input  logic [1:0] code,
  output desc_kind_e kind
);
  always_comb begin
    kind = DK_FAULT;
    if (!lvl2) begin
      case (code)
        2'b10:   kind = DK_SECTION;
        2'b01:   kind = DK_COARSE;
        default: kind = DK_FAULT;
      endcase
    end else if (code[1]) begin
      kind = DK_PAGE;
    end
  end
endmodule

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
  import tw_pkg::*;
(
  input  logic                 in_l2,
  input  logic [BASE_HI_W-1:0] base_hi,
  input  logic [TBL_HI_W-1:0]  tbl_hi,
  input  logic [L1_IDX_W-1:0]  l1_idx,
  input  logic [L2_IDX_W-1:0]  l2_idx,
  output logic [AW-1:0]        addr
);
  always_comb begin
    if (in_l2) addr = l2_addr(tbl_hi, l2_idx);
    else       addr = l1_addr(base_hi, l1_idx);
  end
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       en_now,
  input  logic       rsp_valid,
  input  desc_kind_e kind,
  output logic       req_ready,
  output logic       mem_req,
  output logic       res_valid,
  output logic       in_l2,
  output logic       ev_accept,
  output logic       ev_l1_done,
  output logic       ev_l2_done
);
  walk_st_e st, st_nx;

  assign req_ready  = (st == ST_IDLE);
  assign mem_req    = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign res_valid  = (st == ST_DONE);
  assign in_l2      = (st == ST_L2_REQ) || (st == ST_L2_WAIT);
  assign ev_accept  = req_valid && req_ready;
  assign ev_l1_done = (st == ST_L1_WAIT) && rsp_valid;
  assign ev_l2_done = (st == ST_L2_WAIT) && rsp_valid;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:    if (req_valid) st_nx = en_now ? ST_L1_REQ : ST_DONE;
      ST_L1_REQ:  st_nx = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid) st_nx = (kind == DK_COARSE) ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  st_nx = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid) st_nx = ST_DONE;
      ST_DONE:    st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R9: result and read pulses last a single cycle
  a_r9_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_no_read_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req);
  // R8: after a result the walker is ready again
  a_r8_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import tw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlat_en,
  input  logic [31:0] tbl_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  output logic [31:0] res_paddr,
  output logic        res_cacheable,
  output logic        res_bufferable,
  output logic [3:0]  res_domain,
  output logic        res_page,
  output logic        res_fault
);
  logic [AW-1:0]        va_q;
  logic [BASE_HI_W-1:0] base_hi_q;
  logic                 en_q;
  logic [TBL_HI_W-1:0]  tbl_hi_q;
  logic [DOM_W-1:0]     dom_q;
  xlat_res_t            res_q;

  logic       in_l2, ev_accept, ev_l1_done, ev_l2_done;
  desc_kind_e kind;

  logic unused_bits;
  assign unused_bits = ^{tbl_base[TBL_ALIGN-1:0], mem_rsp_data[4]};

  tw_decode u_decode (
    .lvl2 (in_l2),
    .code (mem_rsp_data[1:0]),
    .kind (kind)
  );

  tw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .en_now     (xlat_en),
    .rsp_valid  (mem_rsp_valid),
    .kind       (kind),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .res_valid  (res_valid),
    .in_l2      (in_l2),
    .ev_accept  (ev_accept),
    .ev_l1_done (ev_l1_done),
    .ev_l2_done (ev_l2_done)
  );

  tw_addr_gen u_addr (
    .in_l2   (in_l2),
    .base_hi (base_hi_q),
    .tbl_hi  (tbl_hi_q),
    .l1_idx  (va_q[AW-1:SEC_W]),
    .l2_idx  (va_q[SEC_W-1:PG_W]),
    .addr    (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      base_hi_q <= '0;
      en_q      <= 1'b0;
      tbl_hi_q  <= '0;
      dom_q     <= '0;
      res_q     <= '0;
    end else begin
      if (ev_accept) begin
        va_q      <= req_vaddr;
        base_hi_q <= tbl_base[AW-1:TBL_ALIGN];
        en_q      <= xlat_en;
        if (!xlat_en) begin
          res_q    <= '0;
          res_q.pa <= req_vaddr;
        end
      end
      if (ev_l1_done) begin
        tbl_hi_q <= mem_rsp_data[AW-1:L2_ALIGN];
        dom_q    <= mem_rsp_data[DOM_LO +: DOM_W];
        if (kind == DK_SECTION) begin
          res_q.pa    <= sect_pa(mem_rsp_data[AW-1:SEC_W], va_q[SEC_W-1:0]);
          res_q.cach  <= mem_rsp_data[C_BIT];
          res_q.buff  <= mem_rsp_data[B_BIT];
          res_q.dom   <= mem_rsp_data[DOM_LO +: DOM_W];
          res_q.page  <= 1'b0;
          res_q.fault <= 1'b0;
        end else if (kind == DK_FAULT) begin
          res_q       <= '0;
          res_q.fault <= 1'b1;
        end
      end
      if (ev_l2_done) begin
        if (kind == DK_PAGE) begin
          res_q.pa    <= page_pa(mem_rsp_data[AW-1:PG_W], va_q[PG_W-1:0]);
          res_q.cach  <= mem_rsp_data[C_BIT];
          res_q.buff  <= mem_rsp_data[B_BIT];
          res_q.dom   <= dom_q;
          res_q.page  <= 1'b1;
          res_q.fault <= 1'b0;
        end else begin
          res_q       <= '0;
          res_q.fault <= 1'b1;
        end
      end
    end
  end

  assign res_paddr      = res_q.pa;
  assign res_cacheable  = res_q.cach;
  assign res_bufferable = res_q.buff;
  assign res_domain     = res_q.dom;
  assign res_page       = res_q.page;
  assign res_fault      = res_q.fault;

  // R1: reads only happen for a walk accepted with translation on
  a_r1_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> en_q);
  // R2: first-level read indexed by the top virtual bits, word aligned
  a_r2_l1_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !in_l2) |-> (mem_addr[TBL_ALIGN-1:2] == va_q[AW-1:SEC_W]
                             && mem_addr[1:0] == 2'b00));
  // R4: second-level read indexed by the middle virtual bits
  a_r4_l2_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && in_l2) |-> (mem_addr[L2_ALIGN-1:2] == va_q[SEC_W-1:PG_W]
                            && mem_addr[1:0] == 2'b00));
  // R3: a section or pass-through result keeps the 1 MB offset
  a_r3_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && !res_page) |-> (res_paddr[SEC_W-1:0] == va_q[SEC_W-1:0]));
  // R5: a page result keeps the 4 KB offset
  a_r5_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_page) |-> (res_paddr[PG_W-1:0] == va_q[PG_W-1:0] && !res_fault));
  // R6, R7: a fault carries no address or attributes
  a_r6_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0 && !res_page && !res_cacheable
                                  && !res_bufferable && res_domain == '0));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_req, mem_rsp_valid = 1'b0;
  logic [31:0] mem_addr, mem_rsp_data = '0;
  logic        res_valid, res_cacheable, res_bufferable, res_page, res_fault;
  logic [31:0] res_paddr;
  logic [3:0]  res_domain;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_paddr(res_paddr),
    .res_cacheable(res_cacheable), .res_bufferable(res_bufferable),
    .res_domain(res_domain), .res_page(res_page), .res_fault(res_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_l1(input logic [31:0] base, input logic [31:0] va);
    return (base & 32'hFFFF_C000) | ((va >> 20) << 2);
  endfunction

  function automatic logic [31:0] m_l2(input logic [31:0] d1, input logic [31:0] va);
    return (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
  endfunction

  // one complete translation with a bench-side memory model
  task automatic run(input string tag, input logic en, input logic [31:0] base,
                     input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                     input bit intrude, input bit disturb);
    logic [31:0] e_pa, e_l2;
    logic        e_c, e_b, e_pg, e_f;
    logic [3:0]  e_dom;
    int          e_reads, nreads, cyc;
    bit          got;
    e_pa = 0; e_c = 0; e_b = 0; e_pg = 0; e_f = 0; e_dom = 0; e_reads = 0;
    e_l2 = m_l2(d1, va);
    if (!en) begin
      e_pa = va;
    end else if (d1[1:0] == 2'b10) begin
      e_reads = 1; e_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      e_c = d1[3]; e_b = d1[2]; e_dom = d1[8:5];
    end else if (d1[1:0] == 2'b01) begin
      e_reads = 2;
      if (d2[1]) begin
        e_pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
        e_c = d2[3]; e_b = d2[2]; e_dom = d1[8:5]; e_pg = 1;
      end else e_f = 1;
    end else begin
      e_reads = 1; e_f = 1;
    end

    @(negedge clk);
    chk({tag, " R8 ready when idle"}, {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; tbl_base = base; xlat_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin
      tbl_base = base ^ 32'hFFFF_C000;
      xlat_en  = ~en;
    end
    nreads = 0; cyc = 0; got = 0;
    while (!got && cyc < 100) begin
      if (res_valid) begin
        got = 1;
        chk({tag, " R1/R9 read count"}, nreads, e_reads);
        chk({tag, " R3/R5 paddr"}, res_paddr, e_pa);
        chk({tag, " R3/R5 cacheable"}, {31'b0, res_cacheable}, {31'b0, e_c});
        chk({tag, " R3/R5 bufferable"}, {31'b0, res_bufferable}, {31'b0, e_b});
        chk({tag, " R3/R5 domain"}, {28'b0, res_domain}, {28'b0, e_dom});
        chk({tag, " R5 page flag"}, {31'b0, res_page}, {31'b0, e_pg});
        chk({tag, " R6/R7 fault"}, {31'b0, res_fault}, {31'b0, e_f});
      end else if (mem_req) begin
        nreads++;
        if (nreads == 1) chk({tag, " R2 first read address"}, mem_addr, m_l1(base, va));
        else             chk({tag, " R4 second read address"}, mem_addr, e_l2);
        if (intrude) req_valid = 1'b1;
        if (intrude) req_vaddr = ~va;
        repeat (1 + ($urandom % 3)) @(negedge clk);
        if (intrude) chk({tag, " R8 not ready while busy"}, {31'b0, req_ready}, 32'd0);
        req_valid = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = (nreads == 1) ? d1 : d2;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        cyc += 4;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!got) begin
      errors++; checks++;
      $display("FAIL %s R9: no result, actual none expected pulse", tag);
    end else begin
      @(negedge clk);
      chk({tag, " R9 result single cycle"}, {31'b0, res_valid}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R8 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R9 reset result idle", {31'b0, res_valid}, 32'd0);
    chk("R9 reset read idle", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;

    run("R3 worked example", 1, 32'h0000_4000, 32'h1234_5678, 32'hABC0_0002, 0, 0, 0);
    run("R3 attrs", 1, 32'h0000_4000, 32'h0FF0_0123, 32'h5550_01EE, 0, 0, 0);
    run("R2 base low bits", 1, 32'h0000_7ABC, 32'hFFFF_FFFF, 32'h0010_000A, 0, 0, 0);
    run("R1 off", 0, 32'h0000_4000, 32'hDEAD_BEEF, 32'hABC0_0002, 0, 0, 0);
    run("R5 page", 1, 32'h0008_0000, 32'h7654_3210, 32'h0000_80A1, 32'h3C00_100E, 0, 0);
    run("R5 page code11", 1, 32'h0008_0000, 32'h0003_4ABC, 32'hFFFF_FDE1, 32'h1234_5673, 0, 0);
    run("R6 l1 code00", 1, 32'h0000_4000, 32'h8000_0000, 32'hFFFF_FFFC, 0, 0, 0);
    run("R6 l1 code11", 1, 32'h0000_4000, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
    run("R7 l2 code00", 1, 32'h0000_4000, 32'h0000_1000, 32'h0000_9001, 32'hFFFF_FFFC, 0, 0);
    run("R7 l2 code01", 1, 32'h0000_4000, 32'h0000_1000, 32'h0000_9001, 32'hFFFF_FFFD, 0, 0);
    run("R8 busy ignore", 1, 32'h0000_4000, 32'h2468_ACE0, 32'h0000_C1E1, 32'h9999_900E, 1, 0);
    run("R10 sample on accept", 1, 32'h0000_4000, 32'h1357_9BDF, 32'h0000_C001, 32'h4444_4006, 0, 1);
    run("R10 sample off", 0, 32'h0000_4000, 32'h1357_9BDF, 32'h0000_C001, 0, 0, 1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] d1r;
      d1r = $urandom;
      if (($urandom % 2) == 0) d1r[1:0] = 2'b01;
      run("R3/R5 random", ($urandom % 8) != 0, $urandom, $urandom, d1r, $urandom,
          ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule